// File: doc/BRIEF.md
# Write-Triggered Single-Read Capture Bridge

This bridge sits between a processor-side register bus and a device register whose reads have side effects, such as a ticket counter that advances each time it is read. The processor stores to the trigger address with a no-cache store. The bridge then performs exactly one handshake read of the device and holds the returned word in an internal buffer. The buffer and a completion flag are then read with ordinary loads. These loads may be speculated, repeated or reissued without reaching the device.

One trigger may arrive while a capture is still running. It is held as a single queued request, and its device read starts as soon as the running read completes. A further trigger, arriving while one is already queued, is stalled on `bus_ready` until the queue slot frees.

Top module: `oneshot_read_bridge`

## Requirements
- R1: A bus write (`bus_sel`=1, `bus_we`=1) to `TRIG_ADDR` that is accepted at a clock edge raises `dev_req` from the next cycle. `dev_req` stays high until a cycle in which `dev_ack` is 1.
- R2: The `dev_rdata` value present in a cycle with `dev_req`=1 and `dev_ack`=1 is stored in the buffer.
- R3: A bus read (`bus_sel`=1, `bus_we`=0) of `BUF_ADDR` returns `{status, buffer}`, with status at bit `DW` and the buffer in bits `DW-1:0`. Repeated reads return the same value and never raise `dev_req`.
- R4: Each accepted trigger produces exactly one device handshake (a cycle with `dev_req`=1 and `dev_ack`=1).
- R5: Status is 0 from the cycle after a trigger is accepted until the last outstanding read completes. After that completion it is 1.
- R6: A trigger accepted while a read is in flight is queued. Its read starts as soon as the current read completes, with `dev_req` staying high.
- R7: A trigger presented while one read is in flight and another is queued sees `bus_ready`=0 and is not accepted.
- R8: A buffer read made while a capture is in flight returns the previously captured value with status 0.
- R9: Reset sets the buffer to 0, status to 0 and `dev_req` to 0, and starts no device read.
- R10: A write to any address other than `TRIG_ADDR` has no effect. A read of any address other than `BUF_ADDR` returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW | Bus word address |
| bus_ready | output | 1 | 0 stalls a trigger write |
| bus_rdata | output | DW+1 | Read data, status in the top bit |
| dev_req | output | 1 | Device read request, held until acknowledged |
| dev_ack | input | 1 | Device read acknowledge, valid only with dev_req |
| dev_rdata | input | DW | Device read data, valid with dev_ack |

## Verification
The assertions assume that the device raises `dev_ack` only while `dev_req` is high, and that a bus master holds a stalled trigger write steady until `bus_ready` returns. The bench's device stub acknowledges only after a fixed number of request cycles. Its bus tasks keep the strobe and address stable until acceptance, so the stimulus never leaves those assumptions.

// File: rtl/oneshot_read_bridge.sv
module oneshot_read_bridge #(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter logic [AW-1:0] TRIG_ADDR = '0,
  parameter logic [AW-1:0] BUF_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  output logic          bus_ready,
  output logic [DW:0]   bus_rdata,
  output logic          dev_req,
  input  logic          dev_ack,
  input  logic [DW-1:0] dev_rdata
);
  logic          busy, pending, done;
  logic [DW-1:0] held;

  wire trig = bus_sel && bus_we && (bus_addr == TRIG_ADDR);
  wire rd   = bus_sel && !bus_we && (bus_addr == BUF_ADDR);
  wire take = trig && bus_ready;
  wire fin  = busy && dev_ack;

  assign bus_ready = !(trig && busy && pending);
  assign dev_req   = busy;
  assign bus_rdata = rd ? {done, held} : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      pending <= 1'b0;
      done    <= 1'b0;
      held    <= '0;
    end else begin
      if (fin) held <= dev_rdata;
      if (!busy) begin
        if (take) begin
          busy <= 1'b1;
          done <= 1'b0;
        end
      end else if (fin) begin
        pending <= 1'b0;
        if (!(pending || take)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (take) begin
        pending <= 1'b1;
      end
    end
  end

  assert_req_held_R1: assert property (@(posedge clk) disable iff (rst)
    (dev_req && !dev_ack) |=> dev_req);

  assert_buf_only_on_ack_R2: assert property (@(posedge clk) disable iff (rst)
    !(dev_req && dev_ack) |=> $stable(held));

  assert_done_after_read_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(dev_req && dev_ack));

  assert_status_low_in_flight_R5: assert property (@(posedge clk) disable iff (rst)
    dev_req |-> !done);

  assert_queue_needs_flight_R6: assert property (@(posedge clk) disable iff (rst)
    pending |-> dev_req);

  assert_stall_when_full_R7: assert property (@(posedge clk) disable iff (rst)
    (trig && !bus_ready) |=> (dev_req || done));
endmodule

// File: tb/sim_oneshot_read_bridge.sv
module sim_oneshot_read_bridge;
  localparam int DW = 16;
  localparam int AW = 4;
  localparam int LAT = 3;
  localparam logic [AW-1:0] TA = 4'h0;
  localparam logic [AW-1:0] BA = 4'h1;
  localparam logic [DW-1:0] BASE = 16'd100;

  logic clk = 0, rst = 1;
  logic bus_sel = 0, bus_we = 0;
  logic [AW-1:0] bus_addr = '0;
  logic bus_ready, dev_req, dev_ack;
  logic [DW:0] bus_rdata;
  logic [DW-1:0] dev_rdata;

  always #4 clk = ~clk;

  oneshot_read_bridge #(.DW(DW), .AW(AW), .TRIG_ADDR(TA), .BUF_ADDR(BA)) u0 (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_ready(bus_ready), .bus_rdata(bus_rdata), .dev_req(dev_req),
    .dev_ack(dev_ack), .dev_rdata(dev_rdata));

  // device stub: ticket counter advanced by each handshake
  logic [DW-1:0] ticket;
  int wcnt, hs;
  assign dev_ack = dev_req && (wcnt == LAT - 1);
  assign dev_rdata = ticket;
  always_ff @(posedge clk) begin
    if (rst) begin
      ticket <= BASE; wcnt <= 0; hs <= 0;
    end else if (dev_req && dev_ack) begin
      ticket <= ticket + 1'b1; wcnt <= 0; hs <= hs + 1;
    end else if (dev_req) begin
      wcnt <= wcnt + 1;
    end
  end

  int total = 0, bad = 0, expect_hs = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [AW-1:0] a);
    bus_sel = 1; bus_we = 1; bus_addr = a;
    #1;
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [AW-1:0] a, output logic [DW:0] d);
    bus_sel = 1; bus_we = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic wait_done(output int cyc);
    logic [DW:0] d;
    cyc = 0;
    d = '0;
    while (!d[DW]) begin
      bus_rd(BA, d);
      cyc++;
    end
  endtask

  // {burst of back-to-back triggers, repeated buffer reads}
  localparam int NV = 5;
  localparam int VEC [NV][2] = '{'{1, 1}, '{1, 6}, '{2, 3}, '{3, 4}, '{1, 10}};

  initial begin
    logic [DW:0] d;
    int cyc, h0;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(dev_req == 0, "R9 dev_req in reset", dev_req, 0);
    rst = 0;
    repeat (4) @(negedge clk);
    chk(dev_req == 0, "R9 no read after reset", dev_req, 0);
    chk(hs == 0, "R9 no handshake after reset", hs, 0);
    bus_rd(BA, d);
    chk(d == '0, "R9 buffer and status zero", d, 0);

    // R10 other address write and read
    bus_wr(4'h2);
    repeat (4) @(negedge clk);
    chk(hs == 0 && dev_req == 0, "R10 stray write ignored", hs, 0);
    bus_rd(4'h2, d);
    chk(d == '0, "R10 non-buffer read zero", d, 0);

    // R1 R5 R8 single trigger
    bus_wr(TA);
    expect_hs++;
    chk(dev_req == 1, "R1 dev_req after trigger", dev_req, 1);
    bus_rd(BA, d);
    chk(d == {1'b0, 16'd0}, "R8 R5 previous value with status 0", d, 0);
    chk(dev_req == 1, "R1 dev_req held until ack", dev_req, 1);
    wait_done(cyc);
    bus_rd(BA, d);
    chk(d == {1'b1, BASE}, "R2 R5 captured value and status", d, {1'b1, BASE});

    // vector table
    for (int v = 0; v < NV; v++) begin
      h0 = hs;
      for (int b = 0; b < VEC[v][0]; b++) bus_wr(TA);
      expect_hs += VEC[v][0];
      wait_done(cyc);
      for (int r = 0; r < VEC[v][1]; r++) begin
        bus_rd(BA, d);
        chk(d == {1'b1, BASE + 16'(expect_hs - 1)}, "R3 R2 repeat buffer read", d, {1'b1, BASE + 16'(expect_hs - 1)});
      end
      repeat (2) @(negedge clk);
      chk(hs - h0 == VEC[v][0], "R4 one handshake per trigger", hs - h0, VEC[v][0]);
      chk(dev_req == 0, "R3 reads raise no request", dev_req, 0);
    end

    // R6 queued trigger follows without gap
    bus_wr(TA);
    bus_wr(TA);
    expect_hs += 2;
    wait_done(cyc);
    chk(cyc <= 2 * LAT + 2, "R6 queued read back to back", cyc, 2 * LAT + 2);
    bus_rd(BA, d);
    chk(d == {1'b1, BASE + 16'(expect_hs - 1)}, "R6 last value captured", d, {1'b1, BASE + 16'(expect_hs - 1)});

    // R7 stall when full
    bus_wr(TA);
    bus_wr(TA);
    expect_hs += 2;
    bus_sel = 1; bus_we = 1; bus_addr = TA;
    #1 chk(bus_ready == 0, "R7 third trigger stalled", bus_ready, 0);
    while (!bus_ready) @(negedge clk);
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
    expect_hs++;
    wait_done(cyc);
    repeat (2) @(negedge clk);
    chk(hs == expect_hs, "R7 R4 stalled trigger served once", hs, expect_hs);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule